// File: doc/BRIEF.md
# Bit-Serial 32-Bit Nonlinear Shift-Register Encryption Engine

This block encrypts one 32-bit block under an 80-bit key. The state sits in two nonlinear feedback shift registers of 13 and 19 bits. The key is held in an 80-bit linear feedback shift register that supplies two subkey bits per round. Each clock cycle computes exactly one round, so an encryption takes 254 cycles. Rounds are not counted by a binary counter. An 8-bit LFSR starts from all ones and the run stops when it reaches the state it holds after 254 steps. Its top bit also acts as an irregular-update flag inside one of the round functions.

The engine is driven by a start strobe with the plaintext and key presented in the same cycle. It answers with a busy level for the whole run, then a one-cycle done pulse. The ciphertext then stays on its output until the next start is accepted. The controller is a three-state machine:

- `ST_IDLE` waits. The transition `idle_to_run` takes place on start.
- `ST_RUN` computes rounds. The transition `run_to_fin` takes place when the round LFSR's next value is the terminal state.
- `ST_FIN` holds done for one cycle. The transition `fin_to_run` takes place on start, and `fin_to_idle` takes place otherwise.

Top module: `nlc_cipher32`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves busy and done low and the ciphertext output at zero from the following cycle.
- R2: A start sampled while busy is low loads the state and the key, and busy is high from the next cycle on. The load places plaintext bits [18:0] in the 19-bit register and bits [31:19] in the 13-bit register, loads key bit j into key position j, and sets the round LFSR to 8'hFF.
- R3: Each round shifts both state registers up by one bit. The 13-bit register (A) takes g at bit 0 and the 19-bit register (B) takes f at bit 0, where ir is round LFSR bit 7 and ka, kb are the round's subkey bits:
  - f = A[12]^A[7]^(A[8]&A[5])^(A[3]&ir)^ka
  - g = B[18]^B[7]^(B[12]&B[10])^(B[8]&B[3])^kb
- R4: The subkey bits follow the sequence k[i] = key[i] for i<80, and k[i] = k[i-80]^k[i-61]^k[i-50]^k[i-13] above that. Round r (counting from 0) uses ka = k[2r] and kb = k[2r+1], so the key register advances two positions per round.
- R5: The round LFSR shifts left each round and takes in the XOR of its bits 7, 6, 4 and 2. A run ends when the LFSR reaches its value after 254 steps, so busy is high for exactly 254 consecutive cycles.
- R6: Done is high for exactly one cycle, the cycle right after the last busy cycle, and is never high together with busy.
- R7: The ciphertext output shows the 13-bit register in bits [31:19] and the 19-bit register in bits [18:0]. When done rises it equals the R3/R4 result, and it holds that value until a start is accepted.
- R8: A start that arrives while busy is high is ignored: the run length and the result are those of the run already under way.
- R9: A start that coincides with the done cycle is accepted at once, and a new 254-cycle run begins on the new inputs.
- R10: A reset asserted during a run ends it: busy drops without a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an encryption when not busy |
| plaintext | input | 32 | Block to encrypt, sampled with start |
| key | input | 80 | Cipher key, sampled with start |
| busy | output | 1 | High while rounds are being computed |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |
| ciphertext | output | 32 | Result, held until the next accepted start |

## Verification
Two things can happen in the same cycle: the done pulse of one run and a new start strobe. The bench raises start exactly in the cycle where done is observed, with fresh plaintext and key. It expects a second run of exactly 254 busy cycles, with a result that matches the bench's arithmetic model on the new inputs. A related collision is a start during the final round cycle, which must be ignored. The bench covers it with starts injected mid-run and judges it by the unchanged run length and ciphertext.

// File: rtl/nlc_pkg.sv
package nlc_pkg;

    localparam int unsigned BLK_W   = 32;
    localparam int unsigned REGA_W  = 13;
    localparam int unsigned REGB_W  = 19;
    localparam int unsigned KEY_W   = 80;
    localparam int unsigned RC_W    = 8;
    localparam int unsigned ROUNDS  = 254;

    localparam logic [RC_W-1:0] RC_INIT = 8'hFF;
    localparam logic [RC_W-1:0] RC_MASK = 8'b1101_0100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } nlc_state_e;

    function automatic logic [RC_W-1:0] rc_step(input logic [RC_W-1:0] s);
        return {s[RC_W-2:0], ^(s & RC_MASK)};
    endfunction

    function automatic logic [RC_W-1:0] rc_advance(input logic [RC_W-1:0] s,
                                                   input int unsigned n);
        logic [RC_W-1:0] v;
        v = s;
        for (int unsigned i = 0; i < n; i++) v = rc_step(v);
        return v;
    endfunction

    localparam logic [RC_W-1:0] RC_TERM = rc_advance(RC_INIT, ROUNDS);

endpackage

// File: rtl/nlc_round_lfsr.sv
module nlc_round_lfsr
    import nlc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output logic ir,
    output logic last
);
    logic [RC_W-1:0] rc_q;
    logic [RC_W-1:0] rc_nx;

    always_comb begin
        rc_nx = rc_step(rc_q);
        ir    = rc_q[RC_W-1];
        last  = (rc_nx == RC_TERM);
    end

    always_ff @(posedge clk) begin
        if (rst)       rc_q <= RC_INIT;
        else if (load) rc_q <= RC_INIT;
        else if (step) rc_q <= rc_nx;
    end

    // R5: a freshly loaded counter never signals the end on its first step
    a_r5_no_early_end: assert property (@(posedge clk) disable iff (rst)
        load |=> !last);

endmodule

// File: rtl/nlc_key_sched.sv
module nlc_key_sched
    import nlc_pkg::*;
#(
    parameter int unsigned TAP_A = 61,
    parameter int unsigned TAP_B = 50,
    parameter int unsigned TAP_C = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [KEY_W-1:0] key_in,
    output logic             ka,
    output logic             kb
);
    localparam int unsigned OFF_A = KEY_W - TAP_A;
    localparam int unsigned OFF_B = KEY_W - TAP_B;
    localparam int unsigned OFF_C = KEY_W - TAP_C;

    logic [KEY_W-1:0] win_q;
    logic [KEY_W-1:0] win_nx;
    logic [1:0]       fresh;

    always_comb begin
        for (int unsigned j = 0; j < 2; j++) begin
            fresh[j] = win_q[j] ^ win_q[OFF_A + j] ^ win_q[OFF_B + j] ^ win_q[OFF_C + j];
        end
        win_nx = {fresh, win_q[KEY_W-1:2]};
        ka     = win_q[0];
        kb     = win_q[1];
    end

    always_ff @(posedge clk) begin
        if (rst)       win_q <= '0;
        else if (load) win_q <= key_in;
        else if (step) win_q <= win_nx;
    end

    // R4: bits already in the window move down two places per round
    a_r4_window_shift: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (win_q[KEY_W-3:0] == $past(win_q[KEY_W-1:2])));

endmodule

// File: rtl/nlc_state_path.sv
module nlc_state_path
    import nlc_pkg::*;
#(
    parameter int unsigned A_T1 = 12,
    parameter int unsigned A_T2 = 7,
    parameter int unsigned A_T3 = 8,
    parameter int unsigned A_T4 = 5,
    parameter int unsigned A_T5 = 3,
    parameter int unsigned B_T1 = 18,
    parameter int unsigned B_T2 = 7,
    parameter int unsigned B_T3 = 12,
    parameter int unsigned B_T4 = 10,
    parameter int unsigned B_T5 = 8,
    parameter int unsigned B_T6 = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [BLK_W-1:0] blk_in,
    input  logic             ir,
    input  logic             ka,
    input  logic             kb,
    output logic [BLK_W-1:0] blk_out
);
    logic [REGA_W-1:0] ra_q;
    logic [REGB_W-1:0] rb_q;
    logic              f_a;
    logic              g_b;

    always_comb begin
        f_a = ra_q[A_T1] ^ ra_q[A_T2] ^ (ra_q[A_T3] & ra_q[A_T4]) ^ (ra_q[A_T5] & ir) ^ ka;
        g_b = rb_q[B_T1] ^ rb_q[B_T2] ^ (rb_q[B_T3] & rb_q[B_T4])
            ^ (rb_q[B_T5] & rb_q[B_T6]) ^ kb;
        blk_out = {ra_q, rb_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q <= '0;
            rb_q <= '0;
        end else if (load) begin
            ra_q <= blk_in[BLK_W-1:REGB_W];
            rb_q <= blk_in[REGB_W-1:0];
        end else if (step) begin
            ra_q <= {ra_q[REGA_W-2:0], g_b};
            rb_q <= {rb_q[REGB_W-2:0], f_a};
        end
    end

    // R3: each register keeps its upper bits as the shifted lower bits
    a_r3_cross_shift: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (ra_q[REGA_W-1:1] == $past(ra_q[REGA_W-2:0]))
                         && (rb_q[REGB_W-1:1] == $past(rb_q[REGB_W-2:0])));

endmodule

// File: rtl/nlc_cipher32.sv
module nlc_cipher32
    import nlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      plaintext,
    input  logic [79:0]      key,
    output logic             busy,
    output logic             done,
    output logic [31:0]      ciphertext
);
    localparam int unsigned LEN_W = $clog2(ROUNDS + 2);

    nlc_state_e st_q;
    nlc_state_e st_nx;
    logic       accept;
    logic       round_en;
    logic       ir;
    logic       last;
    logic       ka;
    logic       kb;

    // next-state logic
    always_comb begin
        st_nx  = st_q;
        accept = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                st_nx  = ST_RUN;      // idle_to_run
                accept = 1'b1;
            end
            ST_RUN: if (last) begin
                st_nx = ST_FIN;       // run_to_fin
            end
            ST_FIN: if (start) begin
                st_nx  = ST_RUN;      // fin_to_run
                accept = 1'b1;
            end else begin
                st_nx = ST_IDLE;      // fin_to_idle
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nx;
    end

    // outputs decoded from state
    always_comb begin
        busy     = 1'b0;
        done     = 1'b0;
        round_en = 1'b0;
        unique case (st_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy     = 1'b1;
                round_en = 1'b1;
            end
            ST_FIN:  done = 1'b1;
            default: ;
        endcase
    end

    nlc_round_lfsr u_rc (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .step (round_en),
        .ir   (ir),
        .last (last)
    );

    nlc_key_sched u_ks (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .step   (round_en),
        .key_in (key),
        .ka     (ka),
        .kb     (kb)
    );

    nlc_state_path u_dp (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .step    (round_en),
        .blk_in  (plaintext),
        .ir      (ir),
        .ka      (ka),
        .kb      (kb),
        .blk_out (ciphertext)
    );

    // run-length tally used only by the checks below
    logic [LEN_W-1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    a_r6_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_after_run: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    a_r5_run_length: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(rst)) |-> (run_len == LEN_W'(ROUNDS)));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(ciphertext));

    a_r8_keep_running: assert property (@(posedge clk) disable iff (rst)
        (busy && start && (run_len < LEN_W'(ROUNDS - 1))) |=> busy);

endmodule

// File: tb/nlc_cipher32_bench.sv
module nlc_cipher32_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] plaintext = '0;
    logic [79:0] key = '0;
    logic        busy;
    logic        done;
    logic [31:0] ciphertext;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    nlc_cipher32 u_nlc_cipher32 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .plaintext  (plaintext),
        .key        (key),
        .busy       (busy),
        .done       (done),
        .ciphertext (ciphertext)
    );

    // arithmetic model built from R2..R5
    function automatic logic [31:0] model(input logic [31:0] p, input logic [79:0] k);
        logic        ks [0:591];
        logic [12:0] a;
        logic [18:0] b;
        logic [7:0]  t;
        logic        fa, gb, ir;
        for (int i = 0; i < 592; i++) begin
            if (i < 80) ks[i] = k[i];
            else        ks[i] = ks[i-80] ^ ks[i-61] ^ ks[i-50] ^ ks[i-13];
        end
        a = p[31:19];
        b = p[18:0];
        t = 8'hFF;
        for (int r = 0; r < 254; r++) begin
            ir = t[7];
            fa = a[12] ^ a[7] ^ (a[8] & a[5]) ^ (a[3] & ir) ^ ks[2*r];
            gb = b[18] ^ b[7] ^ (b[12] & b[10]) ^ (b[8] & b[3]) ^ ks[2*r+1];
            a  = {a[11:0], gb};
            b  = {b[17:0], fa};
            t  = {t[6:0], t[7] ^ t[6] ^ t[4] ^ t[2]};
        end
        return {a, b};
    endfunction

    task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // launch at a prepared point (1 ns after an edge); returns after the done cycle is observed
    task automatic run_enc(input logic [31:0] p, input logic [79:0] k,
                           input int inject_at, input string req);
        int cyc;
        plaintext = p;
        key       = k;
        start     = 1'b1;
        tick();
        start     = 1'b0;
        plaintext = ~p;
        key       = ~k;
        check({req, " busy after start (R2)"}, 80'(busy), 80'd1);
        cyc = 0;
        while (busy && cyc < 400) begin
            cyc++;
            if (cyc == inject_at) start = 1'b1;
            tick();
            start = 1'b0;
        end
        check({req, " busy length (R5)"}, 80'(cyc), 80'd254);
        check({req, " done pulse (R6)"}, 80'(done), 80'd1);
        check({req, " ciphertext (R3/R4/R7)"}, 80'(ciphertext), 80'(model(p, k)));
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin : stim
        logic [31:0] held;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        check("R1 busy", 80'(busy), 80'd0);
        check("R1 done", 80'(done), 80'd0);
        check("R1 ciphertext", 80'(ciphertext), 80'd0);

        // R3/R4: distinct patterns
        run_enc(32'h0000_0000, 80'h0, 0, "zero");
        tick();
        run_enc(32'hFFFF_FFFF, {80{1'b1}}, 0, "ones");
        tick();
        run_enc(32'h1234_5678, 80'hA5A5_0F0F_3C3C_9966_C3D2, 0, "mixed");
        tick();

        // R2: sweep of single-bit plaintexts and keys
        for (int i = 0; i < 32; i++) begin
            run_enc(32'd1 << i, 80'h0, 0, "R2 pt sweep");
            tick();
        end
        for (int i = 0; i < 80; i += 7) begin
            run_enc(32'h0, 80'd1 << i, 0, "R4 key sweep");
            tick();
        end

        // R7: hold after done, with inputs changing and no start
        run_enc(32'hDEAD_BEEF, 80'h0123_4567_89AB_CDEF_1357, 0, "hold");
        held = ciphertext;
        tick();
        check("R6 done single cycle", 80'(done), 80'd0);
        for (int i = 0; i < 6; i++) begin
            plaintext = 32'(i * 32'h1111_1111);
            key = 80'(i);
            tick();
        end
        check("R7 ciphertext held", 80'(ciphertext), 80'(held));
        check("R7 still idle", 80'(busy), 80'd0);

        // R8: starts mid-run and on the final busy cycle are ignored
        run_enc(32'hCAFE_F00D, 80'h5555_AAAA_5555_AAAA_5555, 100, "R8 mid");
        tick();
        run_enc(32'h0F1E_2D3C, 80'h1, 254, "R8 last");
        tick();

        // R9: start in the done cycle
        run_enc(32'h8000_0001, 80'hFEED, 0, "R9 first");
        run_enc(32'h7FFF_FFFE, 80'hBEEF_0000_0000_0000_0001, 0, "R9 second");
        tick();

        // R10: reset during a run
        plaintext = 32'h3;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 50; i++) tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R10 busy cleared", 80'(busy), 80'd0);
        tick();
        check("R10 no done", 80'(done), 80'd0);
        check("R10 ciphertext zero", 80'(ciphertext), 80'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule